// File: doc/BRIEF.md
# Key-Driven Square-Wave Tone Generator

This block turns a bank of seven active-low piano keys into an audible square wave on a single buzzer pin. It also shows the sounding note as a small number for a display. A free-running divider makes a tone tick every `TICK_DIV` system clocks; the default of 10 turns a 50 MHz clock into a 5 MHz tick. A half-period counter advances on each tick. When the counter reaches the terminal count of the selected note, it clears and the buzzer level flips. Each note's terminal count comes from a fixed pitch table.

A second source of notes serves a melody sequencer. When the mode pin selects playback, the keys are ignored. The note is then taken from a 4-bit code that the sequencer delivers over a valid/ready handshake. The accepted code is held until the next transfer. The `seq_ready` pin follows the mode pin, so a sequencer stalls while the keys own the generator. A transfer happens on any clock in which `seq_valid` and `seq_ready` are both high. The code must stay stable while `seq_valid` is high and `seq_ready` is low.

Top module: `tone_keyboard`

## Requirements
- R1: In key mode, when exactly one of `keys_n[6:0]` is low, the buzzer toggles every N+1 tone ticks. Bit 0 through bit 6 give N = 11472, 10216, 9101, 8590, 7653, 6818 and 6060 (middle do through si). When the generator leaves silence, the first rising edge of `buzz` comes at the (N+2)-th clock after the keys change, for `TICK_DIV`=1.
- R2: In key mode, a single low key at bit i sets `note_num` to i+1 (values 1 to 7), starting at the first clock edge after the keys change.
- R3: In key mode, a pattern with no key low or with two or more keys low selects no note. Within two clocks the counter holds at zero and `buzz` is low, and `note_num` keeps its previous value.
- R4: The tone tick fires once every `TICK_DIV` system clocks, so a half period lasts (N+1)·`TICK_DIV` clocks.
- R5: `seq_ready` equals `play_mode`. In playback mode the keys have no effect on `buzz` or `note_num`.
- R6: Note code values are: 0 for rest, 1 to 7 for middle do to si (same counts as R1), and 8 to 12 for low 1, 2, 3, 5, 6 (22900, 20408, 18181, 15267, 13605). When `ALT_LOW5`=1, code 11 uses 14447. Codes 13 to 15 are high 1, 2, 3 (5733, 5108, 4551). A code accepted in playback mode gives its first rising `buzz` edge at the (N+3)-th clock after the accepting edge's input setup, for `TICK_DIV`=1.
- R7: In playback mode, `note_num` shows the last accepted nonzero code. Rest code 0 silences `buzz` within three clocks and leaves `note_num` unchanged.
- R8: Synchronous active-high `rst` clears `buzz`, the counter, `note_num` and the held sequencer code, which is then rest (0).
- R9: If the selected count drops below the counter's present value, `buzz` toggles on the next tick instead of wrapping around.
- R10: In key mode, a `seq_valid` pulse is not accepted. A later switch to playback mode plays the code held before the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| keys_n | input | 7 | Piano keys, active low, bit 0 = do |
| play_mode | input | 1 | 1 = notes from sequencer, 0 = from keys |
| seq_valid | input | 1 | Sequencer code valid |
| seq_ready | output | 1 | Generator accepts a code (equals play_mode) |
| seq_code | input | 4 | Sequencer note code (R6 encoding) |
| buzz | output | 1 | Square-wave output to the buzzer |
| note_num | output | 4 | Code of the last sounding note |

## Verification
A wrong terminal count or a bad counter clear shows up at `buzz` as a rising edge at the wrong clock. For that reason every note's first edge is timed to the exact clock, with the tick forced to every cycle. A stuck selection register shows either as a tone where silence was expected or as a `note_num` that changes when it should hold. Both show within three clocks of the input change. A divider fault shows only as a first edge of `buzz` outside a ten-clock window, about forty-five thousand clocks later. A second instance with the default divider covers this case.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int CODE_W = 4;
  localparam int CNT_W  = 16;
  localparam int NUM_KEYS = 7;

  typedef logic [CODE_W-1:0] note_code_t;
  typedef logic [CNT_W-1:0]  half_cnt_t;

  // Terminal count (in tone ticks) for each note code; 0 means rest.
  function automatic half_cnt_t half_of(note_code_t code, bit alt_low5);
    half_cnt_t h;
    case (code)
      4'd1:  h = 16'd11472;
      4'd2:  h = 16'd10216;
      4'd3:  h = 16'd9101;
      4'd4:  h = 16'd8590;
      4'd5:  h = 16'd7653;
      4'd6:  h = 16'd6818;
      4'd7:  h = 16'd6060;
      4'd8:  h = 16'd22900;
      4'd9:  h = 16'd20408;
      4'd10: h = 16'd18181;
      4'd11: h = alt_low5 ? 16'd14447 : 16'd15267;
      4'd12: h = 16'd13605;
      4'd13: h = 16'd5733;
      4'd14: h = 16'd5108;
      4'd15: h = 16'd4551;
      default: h = '0;
    endcase
    return h;
  endfunction
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_count
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] phase;

      always_ff @(posedge clk) begin
        if (rst)                phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
      end

      assign tick = (phase == LAST);

      // R4
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/note_select.sv
module note_select
  import tone_pkg::*;
#(
  parameter bit ALT_LOW5 = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_KEYS-1:0] keys_n,
  input  logic                play_mode,
  input  logic                seq_valid,
  output logic                seq_ready,
  input  note_code_t          seq_code,
  output half_cnt_t           half_q,
  output note_code_t          note_q
);
  logic [NUM_KEYS-1:0] pressed;
  logic                single;
  note_code_t          key_code;
  note_code_t          held_code;
  note_code_t          src_code;

  assign pressed   = ~keys_n;
  assign single    = ($countones(pressed) == 1);
  assign seq_ready = play_mode;

  always_comb begin
    key_code = '0;
    for (int i = 0; i < NUM_KEYS; i++)
      if (pressed[i]) key_code = note_code_t'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (rst)                         held_code <= '0;
    else if (seq_valid && seq_ready) held_code <= seq_code;
  end

  assign src_code = play_mode ? held_code : (single ? key_code : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= '0;
      note_q <= '0;
    end else begin
      half_q <= half_of(src_code, ALT_LOW5);
      if (src_code != '0) note_q <= src_code;
    end
  end

  // R5
  seq_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_valid && play_mode) |=> (held_code == $past(seq_code)));

  // R10
  seq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !play_mode |=> $stable(held_code));
endmodule

// File: rtl/half_period_gen.sv
module half_period_gen
  import tone_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  half_cnt_t half,
  output logic      buzz
);
  half_cnt_t cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      buzz <= 1'b0;
    end else if (tick) begin
      if (half == '0) begin
        cnt  <= '0;
        buzz <= 1'b0;
      end else if (cnt >= half) begin
        cnt  <= '0;
        buzz <= ~buzz;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4
  buzz_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (buzz != $past(buzz)) |-> $past(tick));

  // R3
  rest_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && half == '0) |=> (!buzz && cnt == '0));

  // R9
  overrun_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && half != '0 && cnt >= half) |=> (cnt == '0 && buzz != $past(buzz)));
endmodule

// File: rtl/tone_keyboard.sv
module tone_keyboard
  import tone_pkg::*;
#(
  parameter int TICK_DIV = 10,
  parameter bit ALT_LOW5 = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [6:0]   keys_n,
  input  logic         play_mode,
  input  logic         seq_valid,
  output logic         seq_ready,
  input  logic [3:0]   seq_code,
  output logic         buzz,
  output logic [3:0]   note_num
);
  logic      tick;
  half_cnt_t half_q;

  tick_divider #(.DIV(TICK_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  note_select #(.ALT_LOW5(ALT_LOW5)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .keys_n    (keys_n),
    .play_mode (play_mode),
    .seq_valid (seq_valid),
    .seq_ready (seq_ready),
    .seq_code  (seq_code),
    .half_q    (half_q),
    .note_q    (note_num)
  );

  half_period_gen u_gen (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .half (half_q),
    .buzz (buzz)
  );

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!buzz && note_num == '0));
endmodule

// File: tb/tb_tone_keyboard.sv
module tb_tone_keyboard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] keys_n = 7'h7F;
  logic       play_mode = 1'b0;
  logic       seq_valid = 1'b0;
  logic [3:0] seq_code = 4'd0;
  logic       seq_ready, buzz, seq_ready_s, buzz_s;
  logic [3:0] note_num, note_num_s;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  tone_keyboard #(.TICK_DIV(1)) dut (
    .clk(clk), .rst(rst), .keys_n(keys_n), .play_mode(play_mode),
    .seq_valid(seq_valid), .seq_ready(seq_ready), .seq_code(seq_code),
    .buzz(buzz), .note_num(note_num));

  tone_keyboard dut_slow (
    .clk(clk), .rst(rst), .keys_n(keys_n), .play_mode(play_mode),
    .seq_valid(seq_valid), .seq_ready(seq_ready_s), .seq_code(seq_code),
    .buzz(buzz_s), .note_num(note_num_s));

  localparam logic [6:0] KEY_PAT [7] = '{7'b1111110, 7'b1111101, 7'b1111011,
    7'b1110111, 7'b1101111, 7'b1011111, 7'b0111111};
  localparam int HALF_EXP [7] = '{11472, 10216, 9101, 8590, 7653, 6818, 6060};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts clock edges until buzz is seen high at a falling edge
  task automatic count_rise(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      seq_valid = 1'b0;
      if (buzz) break;
    end
  endtask

  task automatic hold_silent(input int cycles, input string req);
    int high_seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (buzz) high_seen++;
    end
    chk(high_seen == 0, req, high_seen, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n, last_note;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(buzz == 0, "R8 buzz", buzz, 0);
    chk(note_num == 0, "R8 note_num", note_num, 0);
    chk(seq_ready == 0, "R5 seq_ready key mode", seq_ready, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3: every key in turn
    for (int k = 0; k < 7; k++) begin
      keys_n = KEY_PAT[k];
      count_rise(HALF_EXP[k] + 20, n);
      chk(n == HALF_EXP[k] + 2, "R1 first edge", n, HALF_EXP[k] + 2);
      chk(note_num == k + 1, "R2 note_num", note_num, k + 1);
      keys_n = 7'h7F;
      repeat (3) @(negedge clk);
      chk(buzz == 0, "R3 release silent", buzz, 0);
      chk(note_num == k + 1, "R3 display holds", note_num, k + 1);
    end
    last_note = 7;

    // R3: two keys low
    keys_n = 7'b1111100;
    hold_silent(50, "R3 two keys");
    chk(note_num == last_note, "R3 two keys display", note_num, last_note);
    keys_n = 7'h7F;
    @(negedge clk);

    // R9: shorter count while counter is beyond it
    keys_n = KEY_PAT[0];
    repeat (8000) @(negedge clk);
    chk(buzz == 0, "R9 pre", buzz, 0);
    keys_n = KEY_PAT[6];
    count_rise(50, n);
    chk(n == 2, "R9 early toggle", n, 2);
    keys_n = 7'h7F;
    repeat (3) @(negedge clk);

    // R10: pulse ignored in key mode
    seq_code = 4'd13;
    seq_valid = 1'b1;
    @(negedge clk);
    seq_valid = 1'b0;
    play_mode = 1'b1;
    keys_n = KEY_PAT[2];
    @(negedge clk);
    chk(seq_ready == 1, "R5 seq_ready play mode", seq_ready, 1);
    // R5 keys ignored, held code still rest
    hold_silent(50, "R10 R5 silent");
    chk(note_num == last_note, "R5 keys no display", note_num, last_note);

    // R6 R7: high 1
    seq_code = 4'd13;
    seq_valid = 1'b1;
    count_rise(5800, n);
    chk(n == 5733 + 3, "R6 high1 edge", n, 5736);
    chk(note_num == 13, "R7 display code", note_num, 13);

    // R7: rest holds display
    seq_code = 4'd0;
    seq_valid = 1'b1;
    @(negedge clk);
    seq_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(buzz == 0, "R7 rest silent", buzz, 0);
    chk(note_num == 13, "R7 rest display", note_num, 13);

    // R6: low 6
    seq_code = 4'd12;
    seq_valid = 1'b1;
    count_rise(13700, n);
    chk(n == 13605 + 3, "R6 low6 edge", n, 13608);
    chk(note_num == 12, "R7 display low6", note_num, 12);

    // R8: reset mid-tone
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(buzz == 0, "R8 mid reset buzz", buzz, 0);
    chk(note_num == 0, "R8 mid reset note", note_num, 0);
    hold_silent(20, "R8 held code rest");

    // R4 R6: high 3 on both instances
    begin
      int fast_n = 0;
      int slow_n = 0;
      seq_code = 4'd15;
      seq_valid = 1'b1;
      while (slow_n < 46000) begin
        @(posedge clk);
        slow_n++;
        @(negedge clk);
        seq_valid = 1'b0;
        if (buzz && fast_n == 0) fast_n = slow_n;
        if (buzz_s) break;
      end
      chk(fast_n == 4551 + 3, "R6 high3 edge", fast_n, 4554);
      chk(slow_n >= 45513 && slow_n <= 45522, "R4 divided edge", slow_n, 45513);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule